// File: doc/BRIEF.md
# Master Audio Frame Clock Generator

This block drives the timing side of a serial audio port that acts as clock master. From a single master clock it makes the bit clock, two frame (left/right) clocks, one for playback and one for record, and a one-cycle frame-start pulse. Downstream shifters use these to move sample words. The frame clocks always change together and only on a falling edge of the bit clock, so a receiver that samples on the rising edge sees them settled.

There are two regimes, chosen by `usb_mode`. In normal mode the bit clock is the master clock divided by an even ratio of `2*div_count`, and each frame clock phase spans 32 bit clocks, so one frame is 64 bit clocks with a 50:50 duty cycle. In USB mode the bit clock is the master clock itself (sent out inverted so that register updates fall on its falling edge), and `div_count` gives the frame period N in master clocks. N may be odd: the low phase takes the extra cycle, so N = 375 gives a 188-cycle low phase and a 187-cycle high phase. The mode and the divide count are captured only at the start of a frame, so the software may rewrite them at any time without cutting a frame short.

A three-state machine sequences each frame. ST_INIT is held in reset. Transition INIT_TO_LOW happens on the first clock after reset, loads the configuration and starts the first frame. Transition LOW_TO_HIGH happens when the low-phase count ends and raises the frame clocks. Transition HIGH_TO_LOW happens when the high-phase count ends; it lowers the frame clocks, loads the configuration again and starts a new frame.

Top module: `frame_clk_master`

## Requirements
- R1: While reset is held, both frame clocks and the bit clock are high and `frame_start` is low.
- R2: In normal mode the bit clock has a period of 2*H master clocks, where H is the captured `div_count` (a value of 0 is taken as 1). In each frame it is low for the first H master clocks and then rises.
- R3: In normal mode a frame is low for 64*H master clocks and then high for 64*H master clocks, and it holds exactly 64 bit-clock rising edges.
- R4: In USB mode the bit clock output is the inverted master clock: low while the master clock is high, and high while it is low.
- R5: In USB mode a frame is N master clocks long, where N is the captured `div_count` and values below 2 are taken as 2. The low phase lasts N - floor(N/2) clocks and the high phase floor(N/2) clocks (375 gives 188 low and 187 high).
- R6: In normal mode the frame clocks change only in the master cycle where the bit clock falls from 1 to 0.
- R7: `play_lrc` and `rec_lrc` are identical at all times.
- R8: `frame_start` is high for exactly one master cycle, the first cycle of each low phase, so it coincides with every falling edge of the frame clocks. The first frame starts on the first clock after reset is released.
- R9: `usb_mode` and `div_count` are sampled only on the clock edge that starts a frame. Changes during a frame have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| usb_mode | input | 1 | 1 selects USB mode, 0 selects normal mode |
| div_count | input | DIV_W | Bit-clock half period (normal mode) or frame period (USB mode), in master clocks |
| bclk | output | 1 | Bit clock |
| play_lrc | output | 1 | Playback frame clock, low in the first phase of a frame |
| rec_lrc | output | 1 | Record frame clock, same timing as playback |
| frame_start | output | 1 | One-cycle pulse at the start of each frame |

## Verification
A corrupted phase counter or a wrong state shows up at the ports within one frame, as a low or high phase of the wrong length or a missing `frame_start`. The phase lengths are measured for each frame, with odd, tiny and clamped periods in both modes. A bit-clock divider that drifts relative to the state machine shows up as a frame-clock edge that is not on a bit-clock falling edge, or as a rising-edge count other than 64. A configuration register that loads in the middle of a frame shows up as a wrong length in that same frame, because the bench writes a deliberately wrong setting just after each frame starts.

// File: rtl/fcm_pkg.sv
package fcm_pkg;
    typedef enum logic [1:0] {
        ST_INIT = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } fcm_state_e;

    localparam int unsigned FCM_BCLK_PER_PHASE_LOG2 = 6; // 64 half periods per phase
endpackage

// File: rtl/fcm_cfg_hold.sv
module fcm_cfg_hold #(
    parameter int unsigned DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             usb_mode,
    input  logic [DIV_W-1:0] div_count,
    output logic             act_usb,
    output logic [DIV_W-1:0] act_div
);
    localparam logic [DIV_W-1:0] MIN_USB  = DIV_W'(2);
    localparam logic [DIV_W-1:0] MIN_NORM = DIV_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_usb <= 1'b0;
            act_div <= MIN_NORM;
        end else if (load) begin
            act_usb <= usb_mode;
            if (usb_mode) begin
                act_div <= (div_count < MIN_USB) ? MIN_USB : div_count;
            end else begin
                act_div <= (div_count == '0) ? MIN_NORM : div_count;
            end
        end
    end
endmodule

// File: rtl/fcm_phase_fsm.sv
module fcm_phase_fsm
    import fcm_pkg::*;
#(
    parameter int unsigned DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_usb,
    input  logic [DIV_W-1:0] act_div,
    output logic             enter_low,
    output logic             phase_wrap,
    output logic             lrc_q,
    output logic             start_q
);
    localparam int unsigned CNT_W = DIV_W + FCM_BCLK_PER_PHASE_LOG2;

    fcm_state_e       state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] len_low, len_high, cur_len;
    logic             last;

    always_comb begin
        if (act_usb) begin
            len_low  = CNT_W'(act_div) - CNT_W'(act_div >> 1);
            len_high = CNT_W'(act_div >> 1);
        end else begin
            len_low  = {act_div, {FCM_BCLK_PER_PHASE_LOG2{1'b0}}};
            len_high = {act_div, {FCM_BCLK_PER_PHASE_LOG2{1'b0}}};
        end
        cur_len = (state == ST_HIGH) ? len_high : len_low;
        last    = (cnt == cur_len - CNT_W'(1));
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_INIT: state_nx = ST_LOW;
            ST_LOW:  if (last) state_nx = ST_HIGH;
            ST_HIGH: if (last) state_nx = ST_LOW;
            default: state_nx = ST_INIT;
        endcase
    end

    assign enter_low  = (state == ST_INIT) || ((state == ST_HIGH) && last);
    assign phase_wrap = (state == ST_INIT) || last;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_INIT;
        end else begin
            state <= state_nx;
        end
    end

    // counter and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            lrc_q   <= 1'b1;
            start_q <= 1'b0;
        end else begin
            cnt     <= phase_wrap ? '0 : cnt + CNT_W'(1);
            lrc_q   <= (state_nx == ST_HIGH);
            start_q <= enter_low;
        end
    end
endmodule

// File: rtl/fcm_bclk_div.sv
module fcm_bclk_div #(
    parameter int unsigned DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] act_div,
    output logic             bclk_q
);
    logic [DIV_W-1:0] bcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt   <= '0;
            bclk_q <= 1'b1;
        end else if (restart) begin
            bcnt   <= '0;
            bclk_q <= 1'b0;
        end else if (bcnt == act_div - DIV_W'(1)) begin
            bcnt   <= '0;
            bclk_q <= ~bclk_q;
        end else begin
            bcnt   <= bcnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/frame_clk_master.sv
module frame_clk_master #(
    parameter int unsigned DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             usb_mode,
    input  logic [DIV_W-1:0] div_count,
    output logic             bclk,
    output logic             play_lrc,
    output logic             rec_lrc,
    output logic             frame_start
);
    logic             act_usb;
    logic [DIV_W-1:0] act_div;
    logic             enter_low;
    logic             phase_wrap;
    logic             lrc_q;
    logic             bclk_q;

    fcm_cfg_hold #(.DIV_W(DIV_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (enter_low),
        .usb_mode  (usb_mode),
        .div_count (div_count),
        .act_usb   (act_usb),
        .act_div   (act_div)
    );

    fcm_phase_fsm #(.DIV_W(DIV_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_usb    (act_usb),
        .act_div    (act_div),
        .enter_low  (enter_low),
        .phase_wrap (phase_wrap),
        .lrc_q      (lrc_q),
        .start_q    (frame_start)
    );

    fcm_bclk_div #(.DIV_W(DIV_W)) u_bdiv (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (phase_wrap),
        .act_div (act_div),
        .bclk_q  (bclk_q)
    );

    // USB mode: inverted master clock, so every register update lands on a bit-clock fall
    assign bclk     = act_usb ? ~clk : bclk_q;
    assign play_lrc = lrc_q;
    assign rec_lrc  = lrc_q;
endmodule

// File: rtl/fcm_checker.sv
module fcm_checker #(
    parameter int unsigned DIV_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             play_lrc,
    input logic             rec_lrc,
    input logic             frame_start,
    input logic             bclk_q,
    input logic             act_usb,
    input logic [DIV_W-1:0] act_div
);
    assert_frames_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        play_lrc == rec_lrc);

    assert_lrc_on_bclk_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_usb && !$past(act_usb) && !$stable(play_lrc)) |-> ($past(bclk_q) && !bclk_q));

    assert_fall_gives_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(play_lrc) |-> frame_start);

    assert_start_only_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> $fell(play_lrc));

    assert_start_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    assert_cfg_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |-> ($stable(act_usb) && $stable(act_div)));

    assert_normal_start_bclk_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !act_usb) |-> !bclk_q);
endmodule

bind frame_clk_master fcm_checker #(.DIV_W(DIV_W)) u_fcm_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .play_lrc    (play_lrc),
    .rec_lrc     (rec_lrc),
    .frame_start (frame_start),
    .bclk_q      (bclk_q),
    .act_usb     (act_usb),
    .act_div     (act_div)
);

// File: tb/test_frame_clk_master.sv
module test_frame_clk_master;
    localparam int DIV_W = 10;

    typedef struct {
        bit usb;
        int h;
        int lo;
        int hi;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             usb_mode = 1'b0;
    logic [DIV_W-1:0] div_count = '0;
    logic             bclk, play_lrc, rec_lrc, frame_start;

    int   checks = 0;
    int   fails = 0;
    int   pushed = 0;
    int   frames_started = 0;
    bit   done = 1'b0;
    bit   finished = 1'b0;
    exp_t q[$];

    always #4 clk = ~clk; // 125 MHz

    frame_clk_master #(.DIV_W(DIV_W)) i_frame_clk_master (
        .clk         (clk),
        .rst_n       (rst_n),
        .usb_mode    (usb_mode),
        .div_count   (div_count),
        .bclk        (bclk),
        .play_lrc    (play_lrc),
        .rec_lrc     (rec_lrc),
        .frame_start (frame_start)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic exp_t make_exp(input bit usb, input int div);
        exp_t e;
        int n;
        e.usb = usb;
        if (usb) begin
            n    = (div < 2) ? 2 : div;
            e.h  = 0;
            e.hi = n / 2;
            e.lo = n - n / 2;
        end else begin
            e.h  = (div == 0) ? 1 : div;
            e.lo = 64 * e.h;
            e.hi = 64 * e.h;
        end
        return e;
    endfunction

    task automatic push_frames(input bit usb, input int div, input int n);
        for (int i = 0; i < n; i++) begin
            q.push_back(make_exp(usb, div));
            pushed++;
        end
    endtask

    // change settings while the last queued frame runs; a wrong value is written first (R9)
    task automatic apply(input bit usb, input int div, input int n);
        wait (frames_started == pushed);
        usb_mode  = ~usb;
        div_count = DIV_W'(div + 5);
        @(negedge clk);
        usb_mode  = usb;
        div_count = DIV_W'(div);
        push_frames(usb, div, n);
    endtask

    task automatic probe_usb_bclk();
        wait (frames_started == pushed);
        @(posedge clk);
        #2;
        chk(bclk == 1'b0, "R4 bclk while master clock high", int'(bclk), 0);
        @(negedge clk);
        #2;
        chk(bclk == 1'b1, "R4 bclk while master clock low", int'(bclk), 1);
    endtask

    // monitor: measures each frame at the ports and compares with the queued item
    initial begin : monitor
        exp_t cur;
        int   lo, hi, rises, idx, first_rise, r7_bad;
        bit   started;
        logic pb, pl, pfs;
        lo = 0; hi = 0; rises = 0; idx = 0; first_rise = -1; r7_bad = 0;
        started = 1'b0; pb = 1'b1; pl = 1'b1; pfs = 1'b0;
        cur = make_exp(1'b0, 1);
        wait (rst_n);
        while (!done) begin
            @(negedge clk);
            if (pb == 1'b0 && bclk == 1'b1) begin
                if (rises == 0) first_rise = idx;
                rises++;
            end
            if (play_lrc !== rec_lrc) r7_bad++;
            if (frame_start) begin
                chk(play_lrc == 1'b0 && pl == 1'b1, "R8 frame_start not at frame clock fall",
                    int'(play_lrc), 0);
                chk(!pfs, "R8 frame_start longer than one cycle", int'(pfs), 0);
                if (started) begin
                    if (cur.usb) begin
                        chk(lo == cur.lo, "R5 USB low phase length", lo, cur.lo);
                        chk(hi == cur.hi, "R5 USB high phase length", hi, cur.hi);
                    end else begin
                        chk(lo == cur.lo, "R3 normal low phase length", lo, cur.lo);
                        chk(hi == cur.hi, "R3 normal high phase length", hi, cur.hi);
                        chk(rises == 64, "R3 bit clock rises per frame", rises, 64);
                        chk(first_rise == cur.h, "R2 bit clock low time after frame start",
                            first_rise, cur.h);
                    end
                end
                if (q.size() > 0) begin
                    cur = q.pop_front();
                    started = 1'b1;
                    lo = 0; hi = 0; rises = 0; idx = 0; first_rise = -1;
                    frames_started++;
                    if (!cur.usb)
                        chk(bclk == 1'b0, "R6 bit clock not low at frame start", int'(bclk), 0);
                end else begin
                    done = 1'b1;
                end
            end
            if (started && !cur.usb && play_lrc && !pl)
                chk(pb == 1'b1 && bclk == 1'b0, "R6 frame clock rise off a bit clock fall",
                    int'(bclk), 0);
            if (play_lrc) hi++;
            else lo++;
            idx++;
            pb  = bclk;
            pl  = play_lrc;
            pfs = frame_start;
        end
        chk(r7_bad == 0, "R7 playback and record frame clocks differ", r7_bad, 0);
    end

    // driver
    initial begin : driver
        usb_mode  = 1'b0;
        div_count = DIV_W'(1);
        push_frames(1'b0, 1, 2);
        repeat (3) @(negedge clk);
        chk(play_lrc == 1'b1, "R1 playback frame clock in reset", int'(play_lrc), 1);
        chk(rec_lrc == 1'b1, "R1 record frame clock in reset", int'(rec_lrc), 1);
        chk(bclk == 1'b1, "R1 bit clock in reset", int'(bclk), 1);
        chk(frame_start == 1'b0, "R1 frame_start in reset", int'(frame_start), 0);
        rst_n = 1'b1;
        apply(1'b0, 3, 2);
        apply(1'b1, 375, 2);
        probe_usb_bclk();
        apply(1'b1, 8, 2);
        apply(1'b1, 3, 2);
        apply(1'b1, 1, 2);
        apply(1'b0, 0, 2);
        apply(1'b0, 2, 1);
        wait (done);
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired frames=%0d expected=%0d", frames_started, pushed);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule